// File: doc/BRIEF.md
# Flag Offset Configuration Register File

This block holds ten 8-bit settings for a FIFO's threshold logic. The first two are the almost-empty and almost-full offsets. Software or a controller can load the bank in two ways. In serial mode, bits are shifted in one at a time on a serial clock. In parallel mode, whole bytes are written from the data port while a load strobe is held low.

Neither loading method carries an address. A write pointer steps through registers 1 to 10 and then wraps back to register 1. A separate read pointer follows the same ring and returns register contents on the parallel output. Read-back works in either loading mode.

Consumers do not see the register bank directly. They see an exported copy, and each write reaches that copy a fixed number of clock cycles after the register itself changes. This gives the flag logic a settling window.

Top module: `cfg_offset_bank`

## Requirements
- R1: The bank has NREGS=10 registers of DW=8 bits, addressed 1 to 10. After reset, registers 1 and 2 hold DEF_OFF=7 and the others hold 0. `dout` is 0. `cfg_out` shows the defaults, with register k in bits [8k-1:8k-8].
- R2: When `ser_en_n`=1, `load_n`=0 and `wr_en`=1, `din` is stored in the register at the write pointer on that clock edge, and the write pointer advances by one.
- R3: Both pointers go from register 10 back to register 1.
- R4: When `load_n`=0, `rd_en`=1 and no parallel write is requested, `dout` takes the register at the read pointer on the next edge and the read pointer advances. When no read takes place, `dout` holds its value.
- R5: When `load_n`=1, `wr_en` and `rd_en` change neither a register, nor a pointer, nor `dout`.
- R6: When `ser_en_n`=0, `ser_din` is sampled on each rising edge of `ser_clk`, as seen by `clk`. Each group of eight bits, first bit as MSB, is written to the register at the write pointer, and the pointer then advances. Parallel writes are ignored in this mode.
- R7: When a parallel write and a read are requested in the same cycle, the write is done. The read is dropped: `dout` holds and the read pointer stays.
- R8: A register write appears on `cfg_out` exactly LAT=8 `clk` edges after the edge that stored it. Until then `cfg_out` keeps its old value.
- R9: Reset at any time restores the defaults of R1 and returns both pointers to register 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write clock |
| rst_n | input | 1 | Master reset, active low, asynchronous |
| ser_en_n | input | 1 | Low selects serial loading, high selects parallel loading |
| ser_clk | input | 1 | Serial shift clock, sampled by clk |
| ser_din | input | 1 | Serial data bit |
| load_n | input | 1 | Low steers parallel accesses to the bank |
| wr_en | input | 1 | Parallel write request |
| rd_en | input | 1 | Read-back request |
| din | input | 8 | Parallel write data |
| dout | output | 8 | Read-back data |
| cfg_out | output | 80 | Exported settings after the commit delay |

## Verification
A parallel write and a read can fall in the same cycle. The bench provokes this right after reset by raising `wr_en` and `rd_en` together with `load_n` low for a single cycle. The dropped read is judged in two ways: `dout` must keep its reset value, and the next ordinary read must return register 1 with the newly written byte. Returning register 1 shows that the read pointer did not move.

// File: rtl/cfgbank_pkg.sv
package cfgbank_pkg;

    // Next slot on the ring 1..n.
    function automatic int unsigned cb_ring_next(int unsigned a, int unsigned n);
        return (a >= n) ? 1 : a + 1;
    endfunction

endpackage

// File: rtl/cb_addr_seq.sv
module cb_addr_seq #(
    parameter int NREGS = 10,
    parameter int AW    = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    output logic [AW-1:0] addr
);
    import cfgbank_pkg::*;

    typedef struct packed {
        logic [AW-1:0] addr;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (step) begin
            st_d.addr = AW'(cb_ring_next(32'(st_q.addr), NREGS));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.addr <= AW'(1);
        end else begin
            st_q <= st_d;
        end
    end

    assign addr = st_q.addr;
endmodule

// File: rtl/cb_ser_shift.sv
module cb_ser_shift #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic          sclk,
    input  logic          sdi,
    output logic          word_vld,
    output logic [DW-1:0] word
);
    localparam int CW = $clog2(DW);

    typedef struct packed {
        logic          sclk;
        logic [CW-1:0] cnt;
        logic [DW-1:0] sr;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.sclk = sclk;
        word_vld  = 1'b0;
        word      = {st_q.sr[DW-2:0], sdi};
        if (!enable) begin
            st_d.cnt = '0;
        end else if (sclk && !st_q.sclk) begin
            st_d.sr = {st_q.sr[DW-2:0], sdi};
            if (st_q.cnt == CW'(DW - 1)) begin
                word_vld = 1'b1;
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + CW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/cb_commit_pipe.sv
module cb_commit_pipe #(
    parameter int                      NREGS    = 10,
    parameter int                      AW       = 4,
    parameter int                      DW       = 8,
    parameter int                      LAT      = 8,
    parameter logic [NREGS*DW-1:0]     DEFAULTS = '0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ev_vld,
    input  logic [AW-1:0]         ev_addr,
    input  logic [DW-1:0]         ev_data,
    output logic [NREGS*DW-1:0]   cfg_out
);
    typedef struct packed {
        logic          vld;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
    } ev_t;

    typedef struct packed {
        ev_t [LAT-1:0]               pipe;
        logic [NREGS-1:0][DW-1:0]    shadow;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        st_d.pipe[0] = '{vld: ev_vld, addr: ev_addr, data: ev_data};
        for (int k = 1; k < LAT; k++) begin
            st_d.pipe[k] = st_q.pipe[k-1];
        end
        if (st_q.pipe[LAT-1].vld) begin
            for (int i = 0; i < NREGS; i++) begin
                if (st_q.pipe[LAT-1].addr == AW'(i + 1)) begin
                    st_d.shadow[i] = st_q.pipe[LAT-1].data;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.pipe   <= '0;
            st_q.shadow <= DEFAULTS;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg_out = st_q.shadow;
endmodule

// File: rtl/cfg_offset_bank.sv
module cfg_offset_bank #(
    parameter int NREGS   = 10,
    parameter int DW      = 8,
    parameter int LAT     = 8,
    parameter int DEF_OFF = 7
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ser_en_n,
    input  logic                  ser_clk,
    input  logic                  ser_din,
    input  logic                  load_n,
    input  logic                  wr_en,
    input  logic                  rd_en,
    input  logic [DW-1:0]         din,
    output logic [DW-1:0]         dout,
    output logic [NREGS*DW-1:0]   cfg_out
);
    localparam int AW = $clog2(NREGS + 1);

    function automatic logic [NREGS*DW-1:0] mk_defaults();
        logic [NREGS*DW-1:0] v;
        v = '0;
        for (int i = 0; i < NREGS && i < 2; i++) begin
            v[i*DW +: DW] = DW'(DEF_OFF);
        end
        return v;
    endfunction

    localparam logic [NREGS*DW-1:0] DEFAULTS = mk_defaults();

    typedef struct packed {
        logic [NREGS-1:0][DW-1:0] bank;
        logic [DW-1:0]            dout;
    } st_t;

    st_t st_d, st_q;

    logic          wr_par, rd_go, ser_vld, bank_we;
    logic [DW-1:0] ser_word, we_data;
    logic [AW-1:0] waddr, raddr;

    assign wr_par  = ser_en_n && !load_n && wr_en;
    assign rd_go   = !load_n && rd_en && !wr_par;
    assign bank_we = wr_par || ser_vld;
    assign we_data = ser_en_n ? din : ser_word;

    cb_ser_shift #(.DW(DW)) u_ser (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (!ser_en_n),
        .sclk     (ser_clk),
        .sdi      (ser_din),
        .word_vld (ser_vld),
        .word     (ser_word)
    );

    cb_addr_seq #(.NREGS(NREGS), .AW(AW)) u_wptr (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (bank_we),
        .addr  (waddr)
    );

    cb_addr_seq #(.NREGS(NREGS), .AW(AW)) u_rptr (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (rd_go),
        .addr  (raddr)
    );

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NREGS; i++) begin
            if (bank_we && waddr == AW'(i + 1)) begin
                st_d.bank[i] = we_data;
            end
            if (rd_go && raddr == AW'(i + 1)) begin
                st_d.dout = st_q.bank[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.bank <= DEFAULTS;
            st_q.dout <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    cb_commit_pipe #(
        .NREGS(NREGS), .AW(AW), .DW(DW), .LAT(LAT), .DEFAULTS(DEFAULTS)
    ) u_commit (
        .clk     (clk),
        .rst_n   (rst_n),
        .ev_vld  (bank_we),
        .ev_addr (waddr),
        .ev_data (we_data),
        .cfg_out (cfg_out)
    );

    assign dout = st_q.dout;
endmodule

// File: rtl/cfg_offset_bank_chk.sv
module cfg_offset_bank_chk #(
    parameter int NREGS = 10,
    parameter int AW    = 4,
    parameter int DW    = 8,
    parameter int LAT   = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                ser_en_n,
    input logic                load_n,
    input logic                wr_en,
    input logic                rd_en,
    input logic [DW-1:0]       dout,
    input logic [NREGS*DW-1:0] cfg_out,
    input logic [AW-1:0]       waddr,
    input logic [AW-1:0]       raddr,
    input logic                bank_we
);
    localparam int QW = $clog2(LAT + 2);

    logic [QW-1:0] quiet_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            quiet_q <= QW'(LAT + 1);
        end else if (bank_we) begin
            quiet_q <= '0;
        end else if (quiet_q != QW'(LAT + 1)) begin
            quiet_q <= quiet_q + QW'(1);
        end
    end

    AST_WADDR_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        waddr >= AW'(1) && waddr <= AW'(NREGS)); // R1
    AST_RADDR_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        raddr >= AW'(1) && raddr <= AW'(NREGS)); // R1
    AST_WR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        bank_we && waddr == AW'(NREGS) |=> waddr == AW'(1)); // R3
    AST_DOUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(!load_n && rd_en) |=> $stable(dout)); // R4
    AST_LOAD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        ser_en_n && load_n |=> $stable(waddr) && $stable(raddr) && $stable(dout)); // R5
    AST_SER_NO_PAR: assert property (@(posedge clk) disable iff (!rst_n)
        !ser_en_n && !load_n && wr_en && !bank_we |=> $stable(waddr)); // R6
    AST_COLLIDE: assert property (@(posedge clk) disable iff (!rst_n)
        ser_en_n && !load_n && wr_en && rd_en |=> $stable(raddr) && $stable(dout)); // R7
    AST_EXPORT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        quiet_q == QW'(LAT + 1) |-> $stable(cfg_out)); // R8
    AST_RESET_PTRS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> waddr == AW'(1) && raddr == AW'(1)); // R9
endmodule

bind cfg_offset_bank cfg_offset_bank_chk #(
    .NREGS(NREGS), .AW(AW), .DW(DW), .LAT(LAT)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ser_en_n (ser_en_n),
    .load_n   (load_n),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .dout     (dout),
    .cfg_out  (cfg_out),
    .waddr    (waddr),
    .raddr    (raddr),
    .bank_we  (bank_we)
);

// File: tb/cfg_offset_bank_test.sv
module cfg_offset_bank_test;
    localparam int NREGS = 10;
    localparam int DW    = 8;
    localparam logic [NREGS*DW-1:0] DEF_CFG = 80'h0707;

    typedef struct packed {
        logic          rd;
        logic [DW-1:0] val;
    } vec_t;

    // 10 writes, one wrapping write, then 11 reads that wrap as well.
    localparam vec_t VECS [22] = '{
        '{1'b0, 8'hA1}, '{1'b0, 8'hA2}, '{1'b0, 8'hA3}, '{1'b0, 8'hA4},
        '{1'b0, 8'hA5}, '{1'b0, 8'hA6}, '{1'b0, 8'hA7}, '{1'b0, 8'hA8},
        '{1'b0, 8'hA9}, '{1'b0, 8'hAA}, '{1'b0, 8'hB1},
        '{1'b1, 8'hB1}, '{1'b1, 8'hA2}, '{1'b1, 8'hA3}, '{1'b1, 8'hA4},
        '{1'b1, 8'hA5}, '{1'b1, 8'hA6}, '{1'b1, 8'hA7}, '{1'b1, 8'hA8},
        '{1'b1, 8'hA9}, '{1'b1, 8'hAA}, '{1'b1, 8'hB1}
    };

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                ser_en_n = 1'b1;
    logic                ser_clk = 1'b0;
    logic                ser_din = 1'b0;
    logic                load_n = 1'b1;
    logic                wr_en = 1'b0;
    logic                rd_en = 1'b0;
    logic [DW-1:0]       din = '0;
    logic [DW-1:0]       dout;
    logic [NREGS*DW-1:0] cfg_out;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    cfg_offset_bank uut (
        .clk(clk), .rst_n(rst_n), .ser_en_n(ser_en_n), .ser_clk(ser_clk),
        .ser_din(ser_din), .load_n(load_n), .wr_en(wr_en), .rd_en(rd_en),
        .din(din), .dout(dout), .cfg_out(cfg_out)
    );

    task automatic chk(input string req, input logic [NREGS*DW-1:0] act,
                       input logic [NREGS*DW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic par_write(input logic [DW-1:0] d);
        load_n = 1'b0; wr_en = 1'b1; din = d;
        @(negedge clk);
        load_n = 1'b1; wr_en = 1'b0;
    endtask

    task automatic par_read(output logic [DW-1:0] q);
        load_n = 1'b0; rd_en = 1'b1;
        @(negedge clk);
        load_n = 1'b1; rd_en = 1'b0;
        q = dout;
    endtask

    task automatic ser_byte(input logic [DW-1:0] b);
        for (int i = DW - 1; i >= 0; i--) begin
            ser_din = b[i]; ser_clk = 1'b0;
            @(negedge clk);
            ser_clk = 1'b1;
            repeat (2) @(negedge clk);
            ser_clk = 1'b0;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0]       q;
        logic [NREGS*DW-1:0] exp_cfg;

        do_reset();
        chk("R1 dout after reset", 80'(dout), 80'h0);
        chk("R1 cfg_out defaults", cfg_out, DEF_CFG);

        // R5: load strobe high blocks all accesses
        load_n = 1'b1; wr_en = 1'b1; rd_en = 1'b1; din = 8'hEE;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        chk("R5 dout unchanged", 80'(dout), 80'h0);
        par_read(q); chk("R5 reg1 untouched", 80'(q), 80'h07);
        par_read(q); chk("R5 reg2 untouched", 80'(q), 80'h07);

        // Table: R2 writes, R3 wrap, R4 reads
        do_reset();
        foreach (VECS[i]) begin
            if (!VECS[i].rd) begin
                par_write(VECS[i].val);
            end else begin
                par_read(q);
                chk("R2/R3/R4 table read", 80'(q), 80'(VECS[i].val));
            end
        end
        repeat (10) @(negedge clk);
        exp_cfg = '0;
        exp_cfg[7:0] = 8'hB1;
        for (int i = 1; i < NREGS; i++) exp_cfg[i*DW +: DW] = 8'hA1 + 8'(i);
        chk("R8 cfg_out after table", cfg_out, exp_cfg);

        // R8: commit latency
        do_reset();
        par_write(8'h55);
        repeat (7) @(negedge clk);
        chk("R8 cfg_out still old at 7", cfg_out, DEF_CFG);
        @(negedge clk);
        chk("R8 cfg_out new at 8", cfg_out, {DEF_CFG[79:8], 8'h55});

        // R7: write and read in one cycle
        do_reset();
        load_n = 1'b0; wr_en = 1'b1; rd_en = 1'b1; din = 8'h77;
        @(negedge clk);
        load_n = 1'b1; wr_en = 1'b0; rd_en = 1'b0;
        chk("R7 dout held on collision", 80'(dout), 80'h0);
        par_read(q); chk("R7 write won, read ptr stayed", 80'(q), 80'h77);
        par_read(q); chk("R7 next read reg2", 80'(q), 80'h07);

        // R6: serial loading, parallel write ignored meanwhile
        do_reset();
        ser_en_n = 1'b0;
        ser_byte(8'hC3);
        ser_byte(8'h5A);
        par_write(8'hFF);
        ser_en_n = 1'b1;
        @(negedge clk);
        par_read(q); chk("R6 serial reg1", 80'(q), 80'hC3);
        par_read(q); chk("R6 serial reg2", 80'(q), 80'h5A);
        par_read(q); chk("R6 parallel write ignored", 80'(q), 80'h00);

        // R9: reset in the middle of operation
        do_reset();
        chk("R9 cfg_out defaults", cfg_out, DEF_CFG);
        par_read(q); chk("R9 read ptr back at reg1", 80'(q), 80'h07);
        par_write(8'h42);
        par_read(q); chk("R9 read ptr on reg2", 80'(q), 80'h07);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule